// File: doc/BRIEF.md
# Power-Up Strap Capture and Shared-Pad Clock Router

This block serves the pads of a clock generator that have two jobs. While power-on reset (`por`) is held, those pads are inputs and carry board-level strap levels. The block samples those levels on every clock edge at which `por` is high. When reset ends it keeps the last sample and turns the pads into clock outputs. The kept straps give a four-bit frequency-select default, a select between 48 MHz and 24 MHz, and a two-bit routing mode. The routing mode decides which clock appears on each of the three shared pads.

The clocks to be routed come in as already-generated digital signals, and the block treats them as plain data. Each output pad has its own enable bit from a register file. A disabled pad is driven low and not floated. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure: every pin is a plain level, and inputs reach the pads through combinational logic only.

Top module: `strap_pin_router`

## Requirements
- R1: While a clock edge samples `por` high, all `pad_oe` bits are 0 and all `pad_out` bits are 0 after that edge.
- R2: After the first edge that samples `por` low, every `pad_oe` bit is 1, and it stays 1 for as long as `por` stays low.
- R3: `fs_latched[3:0]` equals `pad_in[3:0]` as sampled at the last edge with `por` high. It does not change while `por` is low, whatever `pad_in` does.
- R4: `sel24_latched` is `pad_in[4]` captured the same way. When running, pad 4 carries `clk_48m` if it is 0 and `clk_24m` if it is 1.
- R5: `mode_latched` is {`pad_in[5]`, `pad_in[6]`} captured the same way (bit 1 is mode A, bit 0 is mode B).
- R6: Mode 00 puts `clk_htt[1]`, `clk_htt[2]` and `clk_pci_alt[2]` on pads 6, 7 and 8.
- R7: Mode 01 puts `clk_htt[1]`, `clk_htt[2]` and `clk_htt[3]` on pads 6, 7 and 8.
- R8: Mode 10 puts `clk_pci_alt[0]`, `clk_pci_alt[1]` and `clk_pci_alt[2]` on pads 6, 7 and 8.
- R9: Mode 11 puts `clk_htt[1]`, `clk_pci_alt[1]` and `clk_pci_alt[2]` on pads 6, 7 and 8.
- R10: The fixed pads carry the following clocks when running: pads 0–2 carry `clk_ref[0..2]`, pad 3 carries `clk_48m` and pad 5 carries `clk_htt[0]`.
- R11: When running, a pad whose `out_en` bit is 0 drives 0 and keeps its `pad_oe` at 1.
- R12: Raising `por` again while running returns the pads to input mode at the next edge, and the straps present then are captured anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por | input | 1 | Power-on reset, active high; strap window |
| pad_in | input | 7 | Strap levels seen on pads 0–6 |
| clk_ref | input | 3 | Reference clocks for pads 0–2 |
| clk_48m | input | 1 | Fixed 48 MHz clock |
| clk_24m | input | 1 | 24 MHz clock |
| clk_htt | input | 4 | Link clocks 0–3 |
| clk_pci_alt | input | 3 | Bus clocks for shared pads (8, 9, 11 of the bus set) |
| out_en | input | 9 | Per-pad enable, 1 = drive clock |
| pad_out | output | 9 | Pad drive values |
| pad_oe | output | 9 | Pad output enables, 0 = floated input |
| fs_latched | output | 4 | Captured frequency-select default |
| sel24_latched | output | 1 | Captured 24/48 select |
| mode_latched | output | 2 | Captured routing mode {A,B} |

## Verification
All four routing modes are captured with both values of the 24/48 select, under changing clock patterns, so that a wrong mode decode, a swapped mode bit or a swapped clock source shows up as a mismatch on a particular pad. The strap inputs are kept moving after release to show that the latch is frozen. Enables are cleared one pad at a time, which separates gating by `out_en` from gating by `pad_oe`. A second reset pulse with different straps checks that capture starts again.

// File: rtl/strap_route_pkg.sv
package strap_route_pkg;
  localparam int NUM_PADS   = 9;
  localparam int NUM_STRAPS = 7;
  localparam int NUM_FS     = 4;
  localparam int NUM_REF    = 3;
  localparam int NUM_HTT    = 4;
  localparam int NUM_ALT    = 3;

  localparam int PAD_SEL  = 4;
  localparam int PAD_HTT0 = 5;
  localparam int PAD_SHA  = 6;
  localparam int PAD_SHB  = 7;
  localparam int PAD_SHC  = 8;

  typedef enum logic [1:0] {
    RM_HTT_PAIR = 2'b00,
    RM_HTT_ALL  = 2'b01,
    RM_ALT_ALL  = 2'b10,
    RM_MIXED    = 2'b11
  } route_mode_e;
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int NSTRAP = 7
) (
  input  logic              clk,
  input  logic              por,
  input  logic [NSTRAP-1:0] strap_in,
  output logic [NSTRAP-1:0] strap_q,
  output logic              run_q
);
  // Straps follow the pads on every edge inside the window; the last one holds.
  always_ff @(posedge clk) begin
    if (por) begin
      strap_q <= strap_in;
      run_q   <= 1'b0;
    end else begin
      run_q   <= 1'b1;
    end
  end
endmodule

// File: rtl/pin_router.sv
module pin_router
  import strap_route_pkg::*;
#(
  parameter int NPAD = NUM_PADS
) (
  input  route_mode_e           mode,
  input  logic                  sel24,
  input  logic [NUM_REF-1:0]    clk_ref,
  input  logic                  clk_48m,
  input  logic                  clk_24m,
  input  logic [NUM_HTT-1:0]    clk_htt,
  input  logic [NUM_ALT-1:0]    clk_pci_alt,
  output logic [NPAD-1:0]       src
);
  logic [2:0] shared_src;

  always_comb begin
    unique case (mode)
      RM_HTT_PAIR: shared_src = {clk_pci_alt[2], clk_htt[2], clk_htt[1]};
      RM_HTT_ALL:  shared_src = {clk_htt[3], clk_htt[2], clk_htt[1]};
      RM_ALT_ALL:  shared_src = {clk_pci_alt[2], clk_pci_alt[1], clk_pci_alt[0]};
      RM_MIXED:    shared_src = {clk_pci_alt[2], clk_pci_alt[1], clk_htt[1]};
      default:     shared_src = '0;
    endcase
  end

  always_comb begin
    src = '0;
    for (int i = 0; i < NUM_REF; i++) src[i] = clk_ref[i];
    src[NUM_REF]  = clk_48m;
    src[PAD_SEL]  = sel24 ? clk_24m : clk_48m;
    src[PAD_HTT0] = clk_htt[0];
    src[PAD_SHA]  = shared_src[0];
    src[PAD_SHB]  = shared_src[1];
    src[PAD_SHC]  = shared_src[2];
  end
endmodule

// File: rtl/pad_gate.sv
module pad_gate #(
  parameter int NPAD = 9
) (
  input  logic            run,
  input  logic [NPAD-1:0] en,
  input  logic [NPAD-1:0] src,
  output logic [NPAD-1:0] pad_out,
  output logic [NPAD-1:0] pad_oe
);
  for (genvar g = 0; g < NPAD; g++) begin : g_pad
    assign pad_oe[g]  = run;
    assign pad_out[g] = run & en[g] & src[g];
  end
endmodule

// File: rtl/strap_pin_router.sv
module strap_pin_router
  import strap_route_pkg::*;
(
  input  logic                  clk,
  input  logic                  por,
  input  logic [NUM_STRAPS-1:0] pad_in,
  input  logic [NUM_REF-1:0]    clk_ref,
  input  logic                  clk_48m,
  input  logic                  clk_24m,
  input  logic [NUM_HTT-1:0]    clk_htt,
  input  logic [NUM_ALT-1:0]    clk_pci_alt,
  input  logic [NUM_PADS-1:0]   out_en,
  output logic [NUM_PADS-1:0]   pad_out,
  output logic [NUM_PADS-1:0]   pad_oe,
  output logic [NUM_FS-1:0]     fs_latched,
  output logic                  sel24_latched,
  output logic [1:0]            mode_latched
);
  logic [NUM_STRAPS-1:0] straps;
  logic                  run;
  logic [NUM_PADS-1:0]   src;
  route_mode_e           mode;

  strap_capture #(.NSTRAP(NUM_STRAPS)) u_cap (
    .clk(clk), .por(por), .strap_in(pad_in), .strap_q(straps), .run_q(run)
  );

  assign fs_latched    = straps[NUM_FS-1:0];
  assign sel24_latched = straps[PAD_SEL];
  assign mode_latched  = {straps[PAD_HTT0], straps[PAD_SHA]};
  assign mode          = route_mode_e'(mode_latched);

  pin_router #(.NPAD(NUM_PADS)) u_route (
    .mode(mode), .sel24(sel24_latched), .clk_ref(clk_ref), .clk_48m(clk_48m),
    .clk_24m(clk_24m), .clk_htt(clk_htt), .clk_pci_alt(clk_pci_alt), .src(src)
  );

  pad_gate #(.NPAD(NUM_PADS)) u_gate (
    .run(run), .en(out_en), .src(src), .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: rtl/strap_pin_router_chk.sv
module strap_pin_router_chk
  import strap_route_pkg::*;
(
  input logic                  clk,
  input logic                  por,
  input logic [NUM_STRAPS-1:0] pad_in,
  input logic [NUM_ALT-1:0]    clk_pci_alt,
  input logic [NUM_PADS-1:0]   out_en,
  input logic [NUM_PADS-1:0]   pad_out,
  input logic [NUM_PADS-1:0]   pad_oe,
  input logic [NUM_FS-1:0]     fs_latched,
  input logic [1:0]            mode_latched
);
  // R1
  window_float_chk: assert property (@(posedge clk) por |=> (pad_oe == '0 && pad_out == '0));
  // R2
  run_drive_chk: assert property (@(posedge clk) !por |=> pad_oe == '1);
  // R3
  fs_capture_chk: assert property (@(posedge clk) por |=> fs_latched == $past(pad_in[NUM_FS-1:0]));
  // R3
  fs_frozen_chk: assert property (@(posedge clk) disable iff (por)
    $past(!por) |-> $stable(fs_latched));
  // R5
  mode_capture_chk: assert property (@(posedge clk) por |=>
    mode_latched == {$past(pad_in[PAD_HTT0]), $past(pad_in[PAD_SHA])});
  // R8
  alt_route_chk: assert property (@(posedge clk) disable iff (por)
    (pad_oe[PAD_SHA] && mode_latched == 2'b10 && out_en[PAD_SHA]) |-> pad_out[PAD_SHA] == clk_pci_alt[0]);
  // R11
  disabled_low_chk: assert property (@(posedge clk) disable iff (por)
    (pad_out & ~out_en) == '0);
endmodule

bind strap_pin_router strap_pin_router_chk u_chk (
  .clk(clk), .por(por), .pad_in(pad_in), .clk_pci_alt(clk_pci_alt),
  .out_en(out_en), .pad_out(pad_out), .pad_oe(pad_oe),
  .fs_latched(fs_latched), .mode_latched(mode_latched)
);

// File: tb/test_strap_pin_router.sv
module test_strap_pin_router;
  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic [6:0] pad_in = 7'h00;
  logic [2:0] clk_ref = '0;
  logic       clk_48m = 1'b0, clk_24m = 1'b0;
  logic [3:0] clk_htt = '0;
  logic [2:0] clk_pci_alt = '0;
  logic [8:0] out_en = '1;
  logic [8:0] pad_out, pad_oe;
  logic [3:0] fs_latched;
  logic       sel24_latched;
  logic [1:0] mode_latched;

  int total = 0, bad = 0;
  bit model_valid = 0;
  bit m_run = 0;
  logic [6:0] m_strap = '0;
  bit r12_phase = 0;
  bit done = 0;

  strap_pin_router i_strap_pin_router (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic ref_src(input int p);
    logic [1:0] md;
    md = {m_strap[5], m_strap[6]};
    case (p)
      0, 1, 2: return clk_ref[p];
      3: return clk_48m;
      4: return m_strap[4] ? clk_24m : clk_48m;
      5: return clk_htt[0];
      6: return (md == 2'b10) ? clk_pci_alt[0] : clk_htt[1];
      7: return (md[1] ^ md[0]) ? ((md == 2'b10) ? clk_pci_alt[1] : clk_htt[2])
                                : ((md == 2'b00) ? clk_htt[2] : clk_pci_alt[1]);
      default: return (md == 2'b01) ? clk_htt[3] : clk_pci_alt[2];
    endcase
  endfunction

  function automatic string route_tag(input int p);
    if (p < 4 || p == 5) return "R10";
    if (p == 4) return "R4";
    case ({m_strap[5], m_strap[6]})
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (por) begin m_strap = pad_in; m_run = 0; end
    else m_run = 1;
    model_valid = 1;
    #2;
    if (!done) begin
      chk(m_run ? (r12_phase ? "R12" : "R2") : "R1", pad_oe, m_run ? 9'h1FF : 9'h000);
      chk("R3", {5'd0, fs_latched}, {5'd0, m_strap[3:0]});
      chk("R4", {8'd0, sel24_latched}, {8'd0, m_strap[4]});
      chk("R5", {7'd0, mode_latched}, {7'd0, m_strap[5], m_strap[6]});
      for (int p = 0; p < 9; p++) begin
        logic e;
        e = m_run & out_en[p] & ref_src(p);
        chk(!m_run ? "R1" : (!out_en[p] ? "R11" : route_tag(p)), {8'd0, pad_out[p]}, {8'd0, e});
      end
    end
  end

  task automatic wiggle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      {clk_ref, clk_48m, clk_24m, clk_htt, clk_pci_alt} = 13'($urandom);
    end
  endtask

  task automatic strap_and_run(input logic [6:0] s);
    @(negedge clk);
    por = 1; pad_in = s;
    wiggle(3);
    @(negedge clk); por = 0;
    wiggle(2);
    pad_in = ~s;  // R3 pad activity after release is ignored
    wiggle(12);
  endtask

  initial begin
    wiggle(4);
    // R6..R9 with both R4 selects and varied R3 frequency straps
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        strap_and_run({m[0], m[1], s[0], 4'(m * 5 + s * 3 + 1)});
      end
    end
    // R11: clear one enable at a time
    for (int p = 0; p < 9; p++) begin
      @(negedge clk); out_en = ~(9'h1 << p);
      wiggle(4);
    end
    @(negedge clk); out_en = '1;
    // R12: reset pulse while running, new straps
    r12_phase = 1;
    strap_and_run(7'b0110101);
    @(negedge clk); por = 1; pad_in = 7'b1001010;
    wiggle(2);
    @(negedge clk); por = 0;
    wiggle(8);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    done = 1;
    bad++; total++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule